// File: doc/BRIEF.md
# Request-Tag Event Qualifier

This block sits between a cache's event sources and its bank of performance counters. Each cycle it sees the event code and strobe of one cache transaction, together with that transaction's request type, 14-bit source identifier and ring channel. It produces one qualified strobe that tells the counter bank whether to count the event. Its configuration comes from three 32-bit control words: a tag control word, a source-ID word and an event control word.

With qualification switched off, every strobe passes. With it on, three filters can narrow counting. The first is a request-type filter, normally used to keep only read requests. The second is a source-ID filter, which only takes effect while the request-type filter is active. The third is a ring-channel filter, which applies only to a fixed window of ring-related event codes. All enabled filters must match in the cycle of the strobe. The result is registered, and the configuration words are used directly, without shadow copies.

Top module: `uc_evq_top`

## Requirements
- R1: While `rst_n` is low, `qual_stb_o` is 0.
- R2: When event control bit 29 is 0, `qual_stb_o` equals `evt_stb_i` of the previous cycle, whatever the transaction fields and the other configuration bits.
- R3: `qual_stb_o` is 1 only in the cycle after a cycle in which `evt_stb_i` was 1 (one register of latency).
- R4: Request filtering is active when tag control bits 0 and 2 are both 1. With qualification on, a strobe then passes only if `txn_req_i` equals tag control bits 9:7. The read request code is 4.
- R5: If either tag control bit 0 or bit 2 is 0, the request type has no effect on the result.
- R6: With request filtering active and tag control bit 3 set, a strobe passes only if `txn_src_i` equals bits 14:1 of the source-ID word.
- R7: Tag control bit 3 and the source-ID word have no effect while request filtering is inactive.
- R8: When event control bits 28:27 are nonzero, a strobe whose event code lies between 0x47 and 0x59 inclusive passes only if `txn_ring_i` equals that field.
- R9: Event codes outside 0x47..0x59 pass regardless of the ring channel. A channel field of 0 disables channel filtering.
- R10: When several filters are enabled, a strobe passes only if all of them match in the same cycle.
- R11: A change to any configuration word applies to a strobe presented in the same cycle as the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_cfg_i | input | 32 | Tag control word |
| src_cfg_i | input | 32 | Source-ID word (ID in bits 14:1) |
| evt_cfg_i | input | 32 | Event control word (channel 28:27, qualify enable 29) |
| txn_req_i | input | 3 | Request type of the transaction |
| txn_src_i | input | 14 | Source identifier of the transaction |
| txn_ring_i | input | 2 | Ring channel of the transaction |
| evt_code_i | input | 8 | Event code |
| evt_stb_i | input | 1 | Event strobe |
| qual_stb_o | output | 1 | Qualified event strobe, one cycle later |

## Verification
The assertions assume that the transaction fields and the configuration words are stable and known at each rising edge. They also assume that the event code and the strobe belong to the same transaction. The stimulus changes every input only on the falling edge and holds it for a full cycle. It also holds the strobe low for the whole reset period, so no check relates a cycle inside reset to the first register load after it.

// File: rtl/uc_evq_pkg.sv
package uc_evq_pkg;
  // Field positions inside the three configuration words
  localparam int CFG_W        = 32;
  localparam int TAG_MARK_BIT = 0;
  localparam int TAG_REQ_BIT  = 2;
  localparam int TAG_SRC_BIT  = 3;
  localparam int TAG_SEL_LSB  = 7;
  localparam int SRC_ID_LSB   = 1;
  localparam int EVC_CH_LSB   = 27;
  localparam int EVC_QUAL_BIT = 29;

  // Per-filter match results
  typedef struct packed {
    logic req_ok;
    logic src_ok;
    logic chan_ok;
  } evq_cond_t;
endpackage

// File: rtl/uc_evq_cfg_dec.sv
module uc_evq_cfg_dec
  import uc_evq_pkg::*;
#(
  parameter int REQ_W = 3,
  parameter int SRC_W = 14,
  parameter int CH_W  = 2
) (
  input  logic [CFG_W-1:0] tag_cfg_i,
  input  logic [CFG_W-1:0] src_cfg_i,
  input  logic [CFG_W-1:0] evt_cfg_i,
  output logic             qual_en_o,
  output logic             req_on_o,
  output logic [REQ_W-1:0] req_sel_o,
  output logic             src_on_o,
  output logic [SRC_W-1:0] src_id_o,
  output logic             chan_on_o,
  output logic [CH_W-1:0]  chan_sel_o
);
  logic unused_cfg_bits;

  always_comb begin
    qual_en_o  = evt_cfg_i[EVC_QUAL_BIT];
    req_on_o   = tag_cfg_i[TAG_MARK_BIT] & tag_cfg_i[TAG_REQ_BIT];
    req_sel_o  = tag_cfg_i[TAG_SEL_LSB +: REQ_W];
    // source matching is only legal while request tagging is live
    src_on_o   = req_on_o & tag_cfg_i[TAG_SRC_BIT];
    src_id_o   = src_cfg_i[SRC_ID_LSB +: SRC_W];
    chan_sel_o = evt_cfg_i[EVC_CH_LSB +: CH_W];
    chan_on_o  = |chan_sel_o;
  end

  assign unused_cfg_bits = ^{tag_cfg_i, src_cfg_i, evt_cfg_i};
endmodule

// File: rtl/uc_evq_win.sv
module uc_evq_win #(
  parameter int          CODE_W = 8,
  parameter logic [7:0]  WIN_LO = 8'h47,
  parameter logic [7:0]  WIN_HI = 8'h59
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o
);
  localparam logic [CODE_W-1:0] LO_C = CODE_W'(WIN_LO);
  localparam logic [CODE_W-1:0] HI_C = CODE_W'(WIN_HI);

  generate
    if (WIN_LO == 8'h00) begin : g_from_zero
      always_comb hit_o = (code_i <= HI_C);
    end else begin : g_bounded
      always_comb hit_o = (code_i >= LO_C) && (code_i <= HI_C);
    end
  endgenerate
endmodule

// File: rtl/uc_evq_match.sv
module uc_evq_match
  import uc_evq_pkg::*;
#(
  parameter int REQ_W = 3,
  parameter int SRC_W = 14,
  parameter int CH_W  = 2
) (
  input  logic             qual_en_i,
  input  logic             req_on_i,
  input  logic [REQ_W-1:0] req_sel_i,
  input  logic             src_on_i,
  input  logic [SRC_W-1:0] src_id_i,
  input  logic             chan_on_i,
  input  logic [CH_W-1:0]  chan_sel_i,
  input  logic             win_hit_i,
  input  logic [REQ_W-1:0] txn_req_i,
  input  logic [SRC_W-1:0] txn_src_i,
  input  logic [CH_W-1:0]  txn_ring_i,
  input  logic             stb_i,
  output evq_cond_t        cond_o,
  output logic             pass_o
);
  always_comb begin
    cond_o.req_ok  = !req_on_i || (txn_req_i == req_sel_i);
    cond_o.src_ok  = !src_on_i || (txn_src_i == src_id_i);
    cond_o.chan_ok = !(chan_on_i && win_hit_i) || (txn_ring_i == chan_sel_i);
    if (!qual_en_i) begin
      pass_o = stb_i;
    end else begin
      pass_o = stb_i & cond_o.req_ok & cond_o.src_ok & cond_o.chan_ok;
    end
  end
endmodule

// File: rtl/uc_evq_top.sv
module uc_evq_top
  import uc_evq_pkg::*;
#(
  parameter int          REQ_W  = 3,
  parameter int          SRC_W  = 14,
  parameter int          CH_W   = 2,
  parameter int          CODE_W = 8,
  parameter logic [7:0]  WIN_LO = 8'h47,
  parameter logic [7:0]  WIN_HI = 8'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       tag_cfg_i,
  input  logic [31:0]       src_cfg_i,
  input  logic [31:0]       evt_cfg_i,
  input  logic [REQ_W-1:0]  txn_req_i,
  input  logic [SRC_W-1:0]  txn_src_i,
  input  logic [CH_W-1:0]   txn_ring_i,
  input  logic [CODE_W-1:0] evt_code_i,
  input  logic              evt_stb_i,
  output logic              qual_stb_o
);
  logic             qual_en, req_on, src_on, chan_on, win_hit, pass_d;
  logic [REQ_W-1:0] req_sel;
  logic [SRC_W-1:0] src_id;
  logic [CH_W-1:0]  chan_sel;
  evq_cond_t        cond;
  logic             qual_q, qual_d;
  logic             unused_cond;

  uc_evq_cfg_dec #(.REQ_W(REQ_W), .SRC_W(SRC_W), .CH_W(CH_W)) u_dec (
    .tag_cfg_i (tag_cfg_i),
    .src_cfg_i (src_cfg_i),
    .evt_cfg_i (evt_cfg_i),
    .qual_en_o (qual_en),
    .req_on_o  (req_on),
    .req_sel_o (req_sel),
    .src_on_o  (src_on),
    .src_id_o  (src_id),
    .chan_on_o (chan_on),
    .chan_sel_o(chan_sel)
  );

  uc_evq_win #(.CODE_W(CODE_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
    .code_i(evt_code_i),
    .hit_o (win_hit)
  );

  uc_evq_match #(.REQ_W(REQ_W), .SRC_W(SRC_W), .CH_W(CH_W)) u_match (
    .qual_en_i (qual_en),
    .req_on_i  (req_on),
    .req_sel_i (req_sel),
    .src_on_i  (src_on),
    .src_id_i  (src_id),
    .chan_on_i (chan_on),
    .chan_sel_i(chan_sel),
    .win_hit_i (win_hit),
    .txn_req_i (txn_req_i),
    .txn_src_i (txn_src_i),
    .txn_ring_i(txn_ring_i),
    .stb_i     (evt_stb_i),
    .cond_o    (cond),
    .pass_o    (pass_d)
  );

  assign unused_cond = ^cond;

  // next state
  always_comb qual_d = pass_d;

  // register, always enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_q <= 1'b0;
    else        qual_q <= qual_d;
  end

  assign qual_stb_o = qual_q;

  // R3: an output pulse always traces back to a strobe
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    qual_stb_o |-> $past(evt_stb_i));

  // R2: qualification off passes the strobe unchanged
  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_cfg_i[EVC_QUAL_BIT]) |=> (qual_stb_o == $past(evt_stb_i)));

  // R4: request-type mismatch blocks the strobe
  assert_req_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cfg_i[EVC_QUAL_BIT] && tag_cfg_i[TAG_MARK_BIT] && tag_cfg_i[TAG_REQ_BIT]
     && txn_req_i != tag_cfg_i[TAG_SEL_LSB +: REQ_W]) |=> !qual_stb_o);

  // R7 and R5: without request tagging and channel field, strobes pass
  assert_src_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cfg_i[EVC_QUAL_BIT] && !(tag_cfg_i[TAG_MARK_BIT] && tag_cfg_i[TAG_REQ_BIT])
     && evt_cfg_i[EVC_CH_LSB +: CH_W] == '0 && evt_stb_i) |=> qual_stb_o);

  // R8: ring mismatch inside the window blocks the strobe
  assert_chan_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cfg_i[EVC_QUAL_BIT] && evt_cfg_i[EVC_CH_LSB +: CH_W] != '0
     && evt_code_i >= CODE_W'(WIN_LO) && evt_code_i <= CODE_W'(WIN_HI)
     && txn_ring_i != evt_cfg_i[EVC_CH_LSB +: CH_W]) |=> !qual_stb_o);
endmodule

// File: tb/sim_uc_evq_top.sv
module sim_uc_evq_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] tag_cfg, src_cfg, evt_cfg;
  logic [2:0]  txn_req;
  logic [13:0] txn_src;
  logic [1:0]  txn_ring;
  logic [7:0]  evt_code;
  logic        evt_stb;
  logic        qual_stb;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   stim_done = 0;
  bit   finished = 0;

  uc_evq_top u0 (
    .clk(clk), .rst_n(rst_n),
    .tag_cfg_i(tag_cfg), .src_cfg_i(src_cfg), .evt_cfg_i(evt_cfg),
    .txn_req_i(txn_req), .txn_src_i(txn_src), .txn_ring_i(txn_ring),
    .evt_code_i(evt_code), .evt_stb_i(evt_stb), .qual_stb_o(qual_stb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected result, built from the requirement text
  function automatic logic model(logic [31:0] t, logic [31:0] s, logic [31:0] e,
                                 logic [2:0] rt, logic [13:0] sid, logic [1:0] rg,
                                 logic [7:0] code, logic stb);
    logic ok;
    logic reqon;
    if (!stb) return 1'b0;
    if (!e[29]) return 1'b1;
    ok = 1'b1;
    reqon = t[0] && t[2];
    if (reqon && rt != t[9:7]) ok = 1'b0;
    if (reqon && t[3] && sid != s[14:1]) ok = 1'b0;
    if (e[28:27] != 2'b00 && code >= 8'h47 && code <= 8'h59 && rg != e[28:27]) ok = 1'b0;
    return ok;
  endfunction

  task automatic drive(input logic [31:0] t, input logic [31:0] s, input logic [31:0] e,
                       input logic [2:0] rt, input logic [13:0] sid, input logic [1:0] rg,
                       input logic [7:0] code, input logic stb, input string tag);
    exp_t it;
    @(negedge clk);
    tag_cfg = t; src_cfg = s; evt_cfg = e;
    txn_req = rt; txn_src = sid; txn_ring = rg; evt_code = code; evt_stb = stb;
    it.exp = model(t, s, e, rt, sid, rg, code, stb);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: result of the cycle driven before this edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        checks++;
        if (qual_stb !== it.exp) begin
          errors++;
          $display("FAIL %s: qual_stb=%b expected %b", it.tag, qual_stb, it.exp);
        end
      end
    end
  end

  localparam logic [31:0] QON      = 32'h2000_0000;
  localparam logic [31:0] TAG_READ = (32'd4 << 7) | 32'h5;   // bits 0,2 and selector 4
  localparam logic [31:0] SRC_ABC  = 32'h0ABC << 1;

  function automatic logic [31:0] chan(input logic [1:0] c);
    return QON | (32'(c) << 27);
  endfunction

  initial begin
    rst_n = 1'b0;
    tag_cfg = '0; src_cfg = '0; evt_cfg = '0;
    txn_req = '0; txn_src = '0; txn_ring = '0; evt_code = '0; evt_stb = 1'b0;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (qual_stb !== 1'b0) begin
        errors++;
        $display("FAIL R1: qual_stb=%b expected 0", qual_stb);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 bypass with filters configured that would otherwise block
    drive(TAG_READ | 32'h8, SRC_ABC, 32'h1800_0000, 3'd1, 14'h1, 2'd1, 8'h50, 1'b1, "R2");
    drive(TAG_READ, '0, '0, 3'd7, 14'h0, 2'd0, 8'h00, 1'b0, "R2");
    drive('0, '0, '0, 3'd0, 14'h0, 2'd0, 8'h10, 1'b1, "R2");
    // R3 no strobe, no output even when all filters match
    drive(TAG_READ, '0, QON, 3'd4, 14'h0, 2'd0, 8'h10, 1'b0, "R3");
    drive('0, '0, QON, 3'd0, 14'h0, 2'd0, 8'h10, 1'b1, "R3");
    drive('0, '0, QON, 3'd0, 14'h0, 2'd0, 8'h10, 1'b0, "R3");
    // R4 read tagging
    drive(TAG_READ, '0, QON, 3'd4, 14'h0, 2'd0, 8'h10, 1'b1, "R4");
    drive(TAG_READ, '0, QON, 3'd2, 14'h0, 2'd0, 8'h10, 1'b1, "R4");
    drive(TAG_READ, '0, QON, 3'd5, 14'h0, 2'd0, 8'h10, 1'b1, "R4");
    // R5 one of the two enable bits missing: type is ignored
    drive((32'd4 << 7) | 32'h1, '0, QON, 3'd2, 14'h0, 2'd0, 8'h10, 1'b1, "R5");
    drive((32'd4 << 7) | 32'h4, '0, QON, 3'd2, 14'h0, 2'd0, 8'h10, 1'b1, "R5");
    // R6 source id match and mismatch
    drive(TAG_READ | 32'h8, SRC_ABC, QON, 3'd4, 14'h0ABC, 2'd0, 8'h10, 1'b1, "R6");
    drive(TAG_READ | 32'h8, SRC_ABC, QON, 3'd4, 14'h0ABD, 2'd0, 8'h10, 1'b1, "R6");
    drive(TAG_READ | 32'h8, SRC_ABC, QON, 3'd4, 14'h2ABC, 2'd0, 8'h10, 1'b1, "R6");
    // R7 source enable without request tagging is ignored
    drive(32'h8 | (32'd4 << 7), SRC_ABC, QON, 3'd1, 14'h0123, 2'd0, 8'h10, 1'b1, "R7");
    drive(32'h9, SRC_ABC, QON, 3'd3, 14'h3FFF, 2'd0, 8'h10, 1'b1, "R7");
    // R8 window edges with channel 2
    drive('0, '0, chan(2'd2), 3'd0, 14'h0, 2'd1, 8'h47, 1'b1, "R8");
    drive('0, '0, chan(2'd2), 3'd0, 14'h0, 2'd3, 8'h59, 1'b1, "R8");
    drive('0, '0, chan(2'd2), 3'd0, 14'h0, 2'd2, 8'h47, 1'b1, "R8");
    drive('0, '0, chan(2'd2), 3'd0, 14'h0, 2'd2, 8'h59, 1'b1, "R8");
    drive('0, '0, chan(2'd2), 3'd0, 14'h0, 2'd0, 8'h50, 1'b1, "R8");
    // R9 outside window, and channel field 0
    drive('0, '0, chan(2'd2), 3'd0, 14'h0, 2'd1, 8'h46, 1'b1, "R9");
    drive('0, '0, chan(2'd2), 3'd0, 14'h0, 2'd1, 8'h5A, 1'b1, "R9");
    drive('0, '0, chan(2'd0), 3'd0, 14'h0, 2'd3, 8'h50, 1'b1, "R9");
    // R10 combined filters: all match, then one failing each
    drive(TAG_READ | 32'h8, SRC_ABC, chan(2'd3), 3'd4, 14'h0ABC, 2'd3, 8'h48, 1'b1, "R10");
    drive(TAG_READ | 32'h8, SRC_ABC, chan(2'd3), 3'd4, 14'h0ABC, 2'd1, 8'h48, 1'b1, "R10");
    drive(TAG_READ | 32'h8, SRC_ABC, chan(2'd3), 3'd4, 14'h0ABB, 2'd3, 8'h48, 1'b1, "R10");
    drive(TAG_READ | 32'h8, SRC_ABC, chan(2'd3), 3'd6, 14'h0ABC, 2'd3, 8'h48, 1'b1, "R10");
    // R11 configuration flips between consecutive cycles
    drive(TAG_READ, '0, QON, 3'd1, 14'h0, 2'd0, 8'h10, 1'b1, "R11");
    drive(TAG_READ, '0, '0,  3'd1, 14'h0, 2'd0, 8'h10, 1'b1, "R11");
    drive(TAG_READ, '0, QON, 3'd1, 14'h0, 2'd0, 8'h10, 1'b1, "R11");
    drive(32'h0, '0, QON, 3'd1, 14'h0, 2'd0, 8'h10, 1'b1, "R11");
    // sweep of codes across the window with a fixed mismatching ring
    for (int c = 8'h40; c < 8'h60; c++) begin
      drive('0, '0, chan(2'd1), 3'd0, 14'h0, 2'd2, 8'(c), 1'b1, "R8");
    end
    drive('0, '0, '0, 3'd0, 14'h0, 2'd0, 8'h00, 1'b0, "R3");
    @(negedge clk);
    @(negedge clk);
    stim_done = 1;
  end

  initial begin
    wait (stim_done);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule